// File: doc/BRIEF.md
# Two-Thread Asymmetric Decode Slot Allocator

Each cycle this block fills a row of five decode lanes from the instruction queue heads of two hardware threads. Lane 0 sits behind the complex decoder. It is the only one that can turn a record into several fused micro-ops, from one to four. Lanes 1 to 4 belong to simple decoders, and each of them turns a single-micro-op record into exactly one micro-op. The complex and simple decoders share one micro-op budget of five lanes. Each extra micro-op the complex decoder produces therefore takes away one simple decoder in that cycle.

Each thread presents a window of up to five records in program order. A record carries a valid bit, a micro-op count, a macro-fusion flag and a tag. The allocator decides which thread decodes. It walks that thread's window in order and stops at the first record it cannot place. It then drives the packed micro-op descriptors and tells each thread how many records to pop. A record whose micro-op count is outside the range the complex decoder handles is sent to a microcode escape output instead of the lanes. The output is combinational. Records are consumed, and the thread preference moves, only in cycles where the consumer asserts ready.

Top module: `dec_slot_alloc`

## Requirements
- R1: The preferred thread decodes if its record 0 is valid; otherwise the other thread decodes. After a cycle with ready high in which either thread had a valid record 0, the preference moves to the thread that did not decode. A cycle with neither thread valid leaves the preference unchanged. `out_thr` names the thread that decodes (0 or 1).
- R2: Record 0 of the decoding thread goes to the complex decoder. When its count `c` (bits [2:0] of the count bus) is 1 to 4, lanes 0 to c-1 carry its tag, with micro-op index 0 to c-1 on `out_sub`.
- R3: Records 1 to 4 (count field at bits [3k+2:3k]) are placed only if their count is 1. Each takes the next free lane. No more than five lanes are used, so a head count of c leaves 5-c simple lanes.
- R4: Records are placed strictly in program order. The first record that is invalid, needs more than one micro-op, has an escape count, or finds no free lane ends the group. No later record is taken.
- R5: At most two records with the fusion flag set, counting record 0, are taken in one cycle. A third fused record ends the group.
- R6: A valid record 0 with count 0 or above 4 raises `esc_vld` and puts its tag on `esc_tag`. No lane is valid, and that one record is consumed.
- R7: `out_vld` is packed from lane 0 upward with no gaps. Lane j carries its tag at `out_tag[8j+7:8j]`, its micro-op index at `out_sub[2j+1:2j]` (0 for simple lanes) and its record's fusion flag at `out_fus[j]`.
- R8: While `out_rdy` is low both take counts are zero, the preference holds, and the lane outputs still show the pending group.
- R9: With `out_rdy` high, the decoding thread's take output gives the number of records consumed (placed or escaped). The other thread's take output is zero.
- R10: After reset the preference is thread 0, and with no valid record no lane, escape or take is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t0_vld | input | 5 | Thread 0 record valid bits, record 0 oldest |
| t0_cnt | input | 15 | Thread 0 micro-op counts, 3 bits per record |
| t0_fus | input | 5 | Thread 0 macro-fusion flags |
| t0_tag | input | 40 | Thread 0 record tags, 8 bits per record |
| t1_vld | input | 5 | Thread 1 record valid bits |
| t1_cnt | input | 15 | Thread 1 micro-op counts |
| t1_fus | input | 5 | Thread 1 macro-fusion flags |
| t1_tag | input | 40 | Thread 1 record tags |
| out_rdy | input | 1 | Consumer accepts the lane group this cycle |
| out_vld | output | 5 | Lane valid bits, packed from lane 0 |
| out_tag | output | 40 | Tag of the record behind each lane |
| out_sub | output | 10 | Micro-op index within its record, per lane |
| out_fus | output | 5 | Fusion flag of the record behind each lane |
| out_thr | output | 1 | Thread decoding this cycle |
| t0_take | output | 3 | Records to pop from thread 0 |
| t1_take | output | 3 | Records to pop from thread 1 |
| esc_vld | output | 1 | Record 0 diverted to microcode escape |
| esc_tag | output | 8 | Tag of the escaped record |

## Verification
The hardest case to reach is the interaction between the preference state and a single-thread fallback, because the preference cannot be seen at the ports. The stimulus first pins the preference to a known thread through a string of fully loaded alternating cycles. It then offers records on only the non-preferred thread, and finally loads both threads identically, so the thread chosen next shows where the preference went. Budget exhaustion, the fused limit and the mid-window stops use windows whose expected cut point is worked out by hand from the head count and the flags.

// File: rtl/dec_slot_alloc.sv
module dec_slot_alloc #(
  parameter int NSLOT = 5,
  parameter int CNT_W = 3,
  parameter int TAG_W = 8,
  parameter int MAXU  = 4,
  parameter int MAXF  = 2,
  parameter int TK_W  = $clog2(NSLOT + 1),
  parameter int SUB_W = $clog2(MAXU)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSLOT-1:0]         t0_vld,
  input  logic [NSLOT*CNT_W-1:0]   t0_cnt,
  input  logic [NSLOT-1:0]         t0_fus,
  input  logic [NSLOT*TAG_W-1:0]   t0_tag,
  input  logic [NSLOT-1:0]         t1_vld,
  input  logic [NSLOT*CNT_W-1:0]   t1_cnt,
  input  logic [NSLOT-1:0]         t1_fus,
  input  logic [NSLOT*TAG_W-1:0]   t1_tag,
  input  logic                     out_rdy,
  output logic [NSLOT-1:0]         out_vld,
  output logic [NSLOT*TAG_W-1:0]   out_tag,
  output logic [NSLOT*SUB_W-1:0]   out_sub,
  output logic [NSLOT-1:0]         out_fus,
  output logic                     out_thr,
  output logic [TK_W-1:0]          t0_take,
  output logic [TK_W-1:0]          t1_take,
  output logic                     esc_vld,
  output logic [TAG_W-1:0]         esc_tag
);

  localparam logic [TK_W-1:0]  NS_T   = TK_W'(NSLOT);
  localparam logic [TK_W-1:0]  MAXF_T = TK_W'(MAXF);
  localparam logic [CNT_W-1:0] MAXU_C = CNT_W'(MAXU);

  logic                   pref_q;
  logic                   sel;
  logic [NSLOT-1:0]       s_vld, s_fus;
  logic [NSLOT*CNT_W-1:0] s_cnt;
  logic [NSLOT*TAG_W-1:0] s_tag;
  logic [CNT_W-1:0]       hcnt;
  logic                   hesc;
  logic [NSLOT-1:0]       l_vld, l_fus;
  logic [TAG_W-1:0]       l_tag [NSLOT];
  logic [SUB_W-1:0]       l_sub [NSLOT];
  logic [TK_W-1:0]        take;

  assign sel   = (pref_q ? t1_vld[0] : t0_vld[0]) ? pref_q : ~pref_q;
  assign s_vld = sel ? t1_vld : t0_vld;
  assign s_fus = sel ? t1_fus : t0_fus;
  assign s_cnt = sel ? t1_cnt : t0_cnt;
  assign s_tag = sel ? t1_tag : t0_tag;

  assign hcnt = s_cnt[CNT_W-1:0];
  assign hesc = s_vld[0] && (hcnt == '0 || hcnt > MAXU_C);

  always_comb begin : walk
    logic [TK_W-1:0]  used;
    logic [TK_W-1:0]  nf;
    logic             stop;
    logic [CNT_W-1:0] c;
    l_vld = '0;
    l_fus = '0;
    take  = '0;
    used  = '0;
    nf    = '0;
    stop  = 1'b0;
    c     = '0;
    for (int j = 0; j < NSLOT; j++) begin
      l_tag[j] = '0;
      l_sub[j] = '0;
    end
    if (s_vld[0] && !hesc) begin
      for (int j = 0; j < MAXU; j++) begin
        if (CNT_W'(j) < hcnt) begin
          l_vld[j] = 1'b1;
          l_tag[j] = s_tag[TAG_W-1:0];
          l_sub[j] = SUB_W'(j);
          l_fus[j] = s_fus[0];
        end
      end
      used = TK_W'(hcnt);
      nf   = TK_W'(s_fus[0]);
      take = TK_W'(1);
      for (int k = 1; k < NSLOT; k++) begin
        c = s_cnt[k*CNT_W +: CNT_W];
        if (!stop && s_vld[k] && c == CNT_W'(1) && used < NS_T &&
            !(s_fus[k] && nf >= MAXF_T)) begin
          l_vld[used] = 1'b1;
          l_tag[used] = s_tag[k*TAG_W +: TAG_W];
          l_fus[used] = s_fus[k];
          used = used + TK_W'(1);
          nf   = nf + TK_W'(s_fus[k]);
          take = take + TK_W'(1);
        end else begin
          stop = 1'b1;
        end
      end
    end else if (hesc) begin
      take = TK_W'(1);
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_pack
    assign out_tag[g*TAG_W +: TAG_W] = l_tag[g];
    assign out_sub[g*SUB_W +: SUB_W] = l_sub[g];
  end

  assign out_vld = l_vld;
  assign out_fus = l_fus;
  assign out_thr = sel;
  assign esc_vld = hesc;
  assign esc_tag = hesc ? s_tag[TAG_W-1:0] : '0;
  assign t0_take = (out_rdy && !sel) ? take : '0;
  assign t1_take = (out_rdy &&  sel) ? take : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                 pref_q <= 1'b0;
    else if (out_rdy && s_vld[0]) pref_q <= ~sel;
  end

endmodule

// File: rtl/dec_slot_alloc_chk.sv
module dec_slot_alloc_chk #(
  parameter int NSLOT = 5,
  parameter int TK_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSLOT-1:0] t0_vld,
  input logic [NSLOT-1:0] t1_vld,
  input logic             out_rdy,
  input logic [NSLOT-1:0] out_vld,
  input logic             out_thr,
  input logic [TK_W-1:0]  t0_take,
  input logic [TK_W-1:0]  t1_take,
  input logic             esc_vld,
  input logic             pref_q
);

  AST_ONE_THREAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    !(t0_take != '0 && t1_take != '0)); // R9

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |-> (t0_take == '0 && t1_take == '0)); // R8

  AST_STALL_PREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_rdy |=> $stable(pref_q)); // R8

  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld & (out_vld + 1'b1)) == '0); // R7

  AST_ESC_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    esc_vld |-> out_vld == '0); // R6

  AST_FALLBACK_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_vld[0] != t1_vld[0]) |-> out_thr == t1_vld[0]); // R1

  AST_PREF_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy && (t0_vld[0] || t1_vld[0])) |=> pref_q != $past(out_thr)); // R1

endmodule

bind dec_slot_alloc dec_slot_alloc_chk #(.NSLOT(NSLOT), .TK_W(TK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .t0_vld(t0_vld), .t1_vld(t1_vld),
  .out_rdy(out_rdy), .out_vld(out_vld), .out_thr(out_thr),
  .t0_take(t0_take), .t1_take(t1_take), .esc_vld(esc_vld), .pref_q(pref_q)
);

// File: tb/dec_slot_alloc_tb_top.sv
module dec_slot_alloc_tb_top;
  localparam int NS = 5, CW = 3, TW = 8, SW = 2, KW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic out_rdy = 1'b1;
  logic [NS-1:0]    iv [2];
  logic [NS-1:0]    ifu[2];
  logic [NS*CW-1:0] ic [2];
  logic [NS*TW-1:0] it [2];
  logic [NS-1:0]    out_vld, out_fus;
  logic [NS*TW-1:0] out_tag;
  logic [NS*SW-1:0] out_sub;
  logic             out_thr, esc_vld;
  logic [KW-1:0]    t0_take, t1_take;
  logic [TW-1:0]    esc_tag;

  dec_slot_alloc dut_i (
    .clk(clk), .rst_n(rst_n),
    .t0_vld(iv[0]), .t0_cnt(ic[0]), .t0_fus(ifu[0]), .t0_tag(it[0]),
    .t1_vld(iv[1]), .t1_cnt(ic[1]), .t1_fus(ifu[1]), .t1_tag(it[1]),
    .out_rdy(out_rdy), .out_vld(out_vld), .out_tag(out_tag), .out_sub(out_sub),
    .out_fus(out_fus), .out_thr(out_thr), .t0_take(t0_take), .t1_take(t1_take),
    .esc_vld(esc_vld), .esc_tag(esc_tag)
  );

  always #10 clk = ~clk;

  int   n_chk = 0, n_fail = 0;
  logic exp_pref = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clr();
    for (int t = 0; t < 2; t++) begin
      iv[t] = '0; ifu[t] = '0; ic[t] = '0; it[t] = '0;
    end
  endtask

  task automatic load(input int t, input int c0, c1, c2, c3, c4,
                      input logic [4:0] vm, input logic [4:0] fm);
    int cs[5];
    cs = '{c0, c1, c2, c3, c4};
    iv[t] = vm; ifu[t] = fm;
    for (int k = 0; k < NS; k++) begin
      ic[t][k*CW +: CW] = CW'(cs[k]);
      it[t][k*TW +: TW] = TW'(t*16 + k);
    end
  endtask

  task automatic load_both(input int c0, c1, c2, c3, c4,
                           input logic [4:0] vm, input logic [4:0] fm);
    load(0, c0, c1, c2, c3, c4, vm, fm);
    load(1, c0, c1, c2, c3, c4, vm, fm);
  endtask

  function automatic int etag(input int k);
    return int'(exp_pref) * 16 + k;
  endfunction

  task automatic take_is(input string r, input int n);
    chk({r, " thread"}, int'(out_thr), int'(exp_pref));
    chk({r, " take"}, exp_pref ? int'(t1_take) : int'(t0_take), n);
    chk({r, " other take"}, exp_pref ? int'(t0_take) : int'(t1_take), 0);
  endtask

  task automatic lane(input string r, input int j, input int rec, input int sub);
    chk({r, " lane tag"}, int'(out_tag[j*TW +: TW]), etag(rec));
    chk({r, " lane sub"}, int'(out_sub[j*SW +: SW]), sub);
  endtask

  task automatic vmask(input string r, input int m);
    chk({r, " vld"}, int'(out_vld), m);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic commit();
    exp_pref = ~exp_pref;
  endtask

  task automatic t_reset();
    clr();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    vmask("R10 idle", 0);
    chk("R10 esc", int'(esc_vld), 0);
    chk("R10 take0", int'(t0_take), 0);
    chk("R10 take1", int'(t1_take), 0);
    step(); load_both(1, 1, 1, 1, 1, 5'b00001, 5'b0); #2;
    take_is("R10 first thread", 1);
    commit();
  endtask

  task automatic t_alt();
    for (int i = 0; i < 3; i++) begin
      step(); load_both(1, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
      vmask("R3 five simple", 5'h1f);
      take_is("R1 R9 alternate", 5);
      lane("R7 lane4", 4, 4, 0);
      chk("R7 fus", int'(out_fus), 0);
      commit();
    end
  endtask

  task automatic t_complex();
    step(); load_both(3, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
    vmask("R2 head3", 5'h1f);
    take_is("R3 head3", 3);
    lane("R2 l0", 0, 0, 0); lane("R2 l1", 1, 0, 1); lane("R2 l2", 2, 0, 2);
    lane("R3 l3", 3, 1, 0); lane("R3 l4", 4, 2, 0);
    commit();
    step(); load_both(4, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
    vmask("R3 head4", 5'h1f);
    take_is("R3 head4", 2);
    lane("R2 l3", 3, 0, 3); lane("R3 l4", 4, 1, 0);
    commit();
    step(); load_both(4, 2, 1, 1, 1, 5'b11111, 5'b0); #2;
    vmask("R4 head4 then multi", 5'h0f);
    take_is("R4 head4 then multi", 1);
    commit();
  endtask

  task automatic t_order();
    step(); load_both(1, 1, 2, 1, 1, 5'b11111, 5'b0); #2;
    vmask("R4 multi mid", 5'h03);
    take_is("R4 multi mid", 2);
    commit();
    step(); load_both(1, 1, 1, 1, 1, 5'b11011, 5'b0); #2;
    vmask("R4 gap", 5'h03);
    take_is("R4 gap", 2);
    commit();
  endtask

  task automatic t_fuse();
    step(); load_both(1, 1, 1, 1, 1, 5'b11111, 5'b11111); #2;
    vmask("R5 all fused", 5'h03);
    take_is("R5 all fused", 2);
    chk("R7 fus lanes", int'(out_fus), 5'h03);
    commit();
    step(); load_both(1, 1, 1, 1, 1, 5'b11111, 5'b11010); #2;
    vmask("R5 third fused", 5'h0f);
    take_is("R5 third fused", 4);
    chk("R7 fus mix", int'(out_fus), 5'h0a);
    commit();
  endtask

  task automatic t_esc();
    step(); load_both(6, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
    chk("R6 esc big", int'(esc_vld), 1);
    chk("R6 esc tag", int'(esc_tag), etag(0));
    vmask("R6 esc big", 0);
    take_is("R6 esc big", 1);
    commit();
    step(); load_both(0, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
    chk("R6 esc zero", int'(esc_vld), 1);
    take_is("R6 esc zero", 1);
    commit();
    step(); load_both(1, 1, 5, 1, 1, 5'b11111, 5'b0); #2;
    chk("R4 esc mid", int'(esc_vld), 0);
    vmask("R4 esc mid", 5'h03);
    take_is("R4 esc mid", 2);
    commit();
  endtask

  task automatic t_stall();
    step(); out_rdy = 1'b0; load_both(1, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
    take_is("R8 stall", 0);
    vmask("R8 stall shown", 5'h1f);
    step(); #2;
    take_is("R8 stall hold", 0);
    step(); out_rdy = 1'b1; #2;
    take_is("R8 release", 5);
    commit();
  endtask

  task automatic t_fall();
    logic srv;
    srv = ~exp_pref;
    step(); clr(); load(int'(srv), 2, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
    chk("R1 fallback thread", int'(out_thr), int'(srv));
    chk("R1 fallback take", srv ? int'(t1_take) : int'(t0_take), 4);
    chk("R9 fallback other", srv ? int'(t0_take) : int'(t1_take), 0);
    exp_pref = ~srv;
    step(); load_both(1, 1, 1, 1, 1, 5'b11111, 5'b0); #2;
    take_is("R1 after fallback", 5);
    commit();
  endtask

  task automatic t_idle();
    step(); clr(); #2;
    vmask("R1 idle", 0);
    chk("R1 idle take0", int'(t0_take), 0);
    chk("R1 idle take1", int'(t1_take), 0);
    step(); load_both(1, 1, 1, 1, 1, 5'b00111, 5'b0); #2;
    take_is("R1 after idle", 3);
    commit();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    t_reset();
    t_alt();
    t_complex();
    t_order();
    t_fuse();
    t_esc();
    t_stall();
    t_fall();
    t_idle();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-run: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule